// File: doc/BRIEF.md
# Single/Double Shift-Rotate Execution Unit

This unit carries out three related single-register operations of a 16-bit processor: a byte swap, a logical shift left and a rotate left through the carry. The operations act on one of the four low general registers. One opcode bit picks a one-step or a two-step form of each operation. The two-step form takes longer, and the unit reports how many cycles the instruction cost.

The unit takes an opcode qualified by a valid strobe, the value of the selected register, and the current carry (C) and overflow (O) flags. One clock later it presents the new register value, the write-enable and the destination index. It also presents the updated sign (S), zero (Z), C and O flags and the cycle cost. Opcodes outside the three groups produce no write, and all other outputs are zero.

The two-step rotate moves two bits through both flags. The old C enters bit 1, the old O enters bit 0, C receives old bit 15 and O receives old bit 14. The two-step swap does not swap twice. It copies the low byte into both halves of the result.

Top module: `shift_rotate_unit`

## Requirements
- R1: With in_valid high, opcodes 0x040–0x057 (bits 9:3 equal to 0x08 for swap, 0x09 for shift-left, 0x0A for rotate) give wr_en=1 one cycle later, with wr_sel equal to opcode bits 1:0. Any other opcode, or in_valid low, gives wr_en=0 with result, flags, wr_sel and cycles all zero.
- R2: cycles is 6 when opcode bit 2 is 0 (single form) and 8 when it is 1 (double form).
- R3: A single swap returns {low byte, high byte} of the register value.
- R4: A double swap returns {low byte, low byte}.
- R5: For a swap, s_out is bit 7 of the result and z_out is 1 when the 16-bit result is zero. c_out and o_out equal c_in and o_in.
- R6: A shift-left moves the value left by 1 (single form) or by 2 (double form), filling with zeros and truncating to 16 bits. s_out is result bit 15, z_out is result==0, and c_out and o_out equal the inputs.
- R7: A single rotate returns {value[14:0], c_in}. c_out is value bit 15 and o_out equals o_in. s_out is bit 15 and z_out is result==0.
- R8: A double rotate returns {value[13:0], c_in, o_in}. c_out is value bit 15 and o_out is value bit 14. s_out and z_out follow the same rule as in R7.
- R9: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies opcode and operands |
| opcode | input | 10 | Instruction word |
| reg_val | input | 16 | Value of the selected register |
| c_in | input | 1 | Current carry flag |
| o_in | input | 1 | Current overflow flag |
| wr_en | output | 1 | Register write-enable |
| wr_sel | output | 2 | Destination register index |
| result | output | 16 | Value to write back |
| s_out | output | 1 | New sign flag |
| z_out | output | 1 | New zero flag |
| c_out | output | 1 | New carry flag |
| o_out | output | 1 | New overflow flag |
| cycles | output | 4 | Cycle cost of the instruction |

## Verification
The bench applies every one of the 1024 opcodes to a set of values that exercise the edge bits, under all four combinations of C and O. It also applies them with in_valid low.

Values with bit 15 or bit 14 set catch a rotate that drops a bit or routes it into the wrong flag. Values whose bits run off the top during a shift must give Z=1. A swap that takes S from bit 15 shows up on 0x00FF versus 0xFF00. A double swap that swaps twice would return the input unchanged, and the bench detects it. Neighbouring opcodes 0x03F and 0x058 must leave wr_en low.

// File: rtl/shift_rot_pkg.sv
package shift_rot_pkg;
   typedef enum logic [1:0] {
      OPK_NONE = 2'd0,
      OPK_SWAP = 2'd1,
      OPK_SLL  = 2'd2,
      OPK_RLC  = 2'd3
   } opk_e;

   typedef struct packed {
      opk_e       kind;
      logic       dbl;
      logic [1:0] sel;
   } dec_t;

   localparam logic [6:0] GRP_SWAP = 7'h08;
   localparam logic [6:0] GRP_SLL  = 7'h09;
   localparam logic [6:0] GRP_RLC  = 7'h0A;
endpackage

// File: rtl/sr_decode.sv
module sr_decode
   import shift_rot_pkg::*;
#(
   parameter int OPC_W = 10
) (
   input  logic             in_valid,
   input  logic [OPC_W-1:0] opcode,
   output dec_t             dec
);
   localparam int GRP_W = OPC_W - 3;

   initial begin
      assert (OPC_W >= 10) else $error("OPC_W must be at least 10");
   end

   logic [GRP_W-1:0] grp;
   assign grp = opcode[OPC_W-1:3];

   always_comb begin
      dec.kind = OPK_NONE;
      dec.dbl  = opcode[2];
      dec.sel  = opcode[1:0];
      if (in_valid) begin
         if (grp == GRP_W'(GRP_SWAP))     dec.kind = OPK_SWAP;
         else if (grp == GRP_W'(GRP_SLL)) dec.kind = OPK_SLL;
         else if (grp == GRP_W'(GRP_RLC)) dec.kind = OPK_RLC;
      end
   end
endmodule

// File: rtl/sr_datapath.sv
module sr_datapath
   import shift_rot_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  dec_t              dec,
   input  logic [DATA_W-1:0] val,
   input  logic              c_in,
   input  logic              o_in,
   output logic [DATA_W-1:0] res,
   output logic              s_out,
   output logic              z_out,
   output logic              c_out,
   output logic              o_out
);
   localparam int HALF = DATA_W / 2;

   initial begin
      assert (DATA_W >= 4 && (DATA_W % 2) == 0) else $error("DATA_W must be even and >= 4");
   end

   logic [DATA_W-1:0] sh1, sh2, rot1, rot2;

   genvar i;
   generate
      for (i = 0; i < DATA_W; i++) begin : g_bit
         if (i == 0) begin : g_lsb
            assign sh1[i]  = 1'b0;
            assign sh2[i]  = 1'b0;
            assign rot1[i] = c_in;
            assign rot2[i] = o_in;
         end else if (i == 1) begin : g_b1
            assign sh1[i]  = val[0];
            assign sh2[i]  = 1'b0;
            assign rot1[i] = val[0];
            assign rot2[i] = c_in;
         end else begin : g_up
            assign sh1[i]  = val[i-1];
            assign sh2[i]  = val[i-2];
            assign rot1[i] = val[i-1];
            assign rot2[i] = val[i-2];
         end
      end
   endgenerate

   always_comb begin
      res   = '0;
      c_out = c_in;
      o_out = o_in;
      s_out = 1'b0;
      unique case (dec.kind)
         OPK_SWAP: begin
            res   = dec.dbl ? {val[HALF-1:0], val[HALF-1:0]}
                            : {val[HALF-1:0], val[DATA_W-1:HALF]};
            s_out = res[HALF-1];
         end
         OPK_SLL: begin
            res   = dec.dbl ? sh2 : sh1;
            s_out = res[DATA_W-1];
         end
         OPK_RLC: begin
            res   = dec.dbl ? rot2 : rot1;
            c_out = val[DATA_W-1];
            if (dec.dbl) o_out = val[DATA_W-2];
            s_out = res[DATA_W-1];
         end
         default: begin
            c_out = 1'b0;
            o_out = 1'b0;
         end
      endcase
      z_out = (dec.kind != OPK_NONE) && (res == '0);
   end

   always_comb begin
      if (dec.kind == OPK_SWAP && dec.dbl)
         AST_DSWAP_HALVES: assert (res[DATA_W-1:HALF] == val[HALF-1:0]); // R4
   end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
   import shift_rot_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int OPC_W      = 10,
   parameter int CYC_SINGLE = 6,
   parameter int CYC_DOUBLE = 8,
   parameter int CYC_W      = $clog2(CYC_DOUBLE + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [DATA_W-1:0] reg_val,
   input  logic              c_in,
   input  logic              o_in,
   output logic              wr_en,
   output logic [1:0]        wr_sel,
   output logic [DATA_W-1:0] result,
   output logic              s_out,
   output logic              z_out,
   output logic              c_out,
   output logic              o_out,
   output logic [CYC_W-1:0]  cycles
);
   localparam int GRP_W = OPC_W - 3;

   initial begin
      assert (CYC_DOUBLE > CYC_SINGLE && CYC_SINGLE > 0) else $error("cycle costs out of order");
   end

   dec_t              dec;
   logic [DATA_W-1:0] n_res;
   logic              n_s, n_z, n_c, n_o;

   sr_decode #(.OPC_W(OPC_W)) u_dec (
      .in_valid(in_valid), .opcode(opcode), .dec(dec)
   );

   sr_datapath #(.DATA_W(DATA_W)) u_dp (
      .dec(dec), .val(reg_val), .c_in(c_in), .o_in(o_in),
      .res(n_res), .s_out(n_s), .z_out(n_z), .c_out(n_c), .o_out(n_o)
   );

   logic act;
   assign act = (dec.kind != OPK_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n || !act) begin
         wr_en  <= 1'b0;
         wr_sel <= '0;
         result <= '0;
         s_out  <= 1'b0;
         z_out  <= 1'b0;
         c_out  <= 1'b0;
         o_out  <= 1'b0;
         cycles <= '0;
      end else begin
         wr_en  <= 1'b1;
         wr_sel <= dec.sel;
         result <= n_res;
         s_out  <= n_s;
         z_out  <= n_z;
         c_out  <= n_c;
         o_out  <= n_o;
         cycles <= dec.dbl ? CYC_W'(CYC_DOUBLE) : CYC_W'(CYC_SINGLE);
      end
   end

   logic in_swap, in_rlc;
   assign in_swap = in_valid && (opcode[OPC_W-1:3] == GRP_W'(GRP_SWAP));
   assign in_rlc  = in_valid && (opcode[OPC_W-1:3] == GRP_W'(GRP_RLC));

   AST_CYC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (cycles == CYC_W'(CYC_SINGLE) || cycles == CYC_W'(CYC_DOUBLE))); // R2
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> (result == '0 && cycles == '0 && !c_out && !o_out)); // R1
   AST_SEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> wr_sel == $past(opcode[1:0])); // R1
   AST_SWAP_KEEPS_CO: assert property (@(posedge clk) disable iff (!rst_n)
      in_swap |=> (wr_en && c_out == $past(c_in) && o_out == $past(o_in))); // R5
   AST_RLC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      in_rlc |=> (wr_en && c_out == $past(reg_val[DATA_W-1]))); // R7
   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> z_out == (result == '0)); // R6
endmodule

// File: tb/shift_rotate_unit_tb.sv
module shift_rotate_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [9:0]  opcode = '0;
   logic [15:0] reg_val = '0;
   logic        c_in = 1'b0, o_in = 1'b0;
   logic        wr_en;
   logic [1:0]  wr_sel;
   logic [15:0] result;
   logic        s_out, z_out, c_out, o_out;
   logic [3:0]  cycles;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   shift_rotate_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .reg_val(reg_val), .c_in(c_in), .o_in(o_in), .wr_en(wr_en),
      .wr_sel(wr_sel), .result(result), .s_out(s_out), .z_out(z_out),
      .c_out(c_out), .o_out(o_out), .cycles(cycles)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h (op=0x%03h val=0x%04h c=%0d o=%0d v=%0d)",
                  req, what, act, exp, opcode, reg_val, c_in, o_in, in_valid);
      end
   endtask

   task automatic run_one(input logic v, input int op, input int val, input logic c, input logic o);
      int grp, dbl, e_res, e_s, e_c, e_o, e_cyc;
      string rq;
      @(negedge clk);
      in_valid = v; opcode = op[9:0]; reg_val = val[15:0]; c_in = c; o_in = o;
      @(posedge clk);
      @(negedge clk);
      grp = op >> 3;
      dbl = (op >> 2) & 1;
      if (!v || grp < 8 || grp > 10) begin
         chk("R1", "wr_en", wr_en, 0);
         chk("R1", "idle outputs", {wr_sel, result, s_out, z_out, c_out, o_out, cycles}, 0);
      end else begin
         e_c = c; e_o = o;
         if (grp == 8) begin
            rq = dbl ? "R4" : "R3";
            e_res = dbl ? (((val & 255) << 8) | (val & 255))
                        : (((val & 255) << 8) | ((val >> 8) & 255));
            e_s = (e_res >> 7) & 1;
         end else if (grp == 9) begin
            rq = "R6";
            e_res = (val << (dbl ? 2 : 1)) & 16'hFFFF;
            e_s = (e_res >> 15) & 1;
         end else begin
            rq = dbl ? "R8" : "R7";
            e_c = (val >> 15) & 1;
            if (dbl) begin
               e_res = ((val << 2) | (c << 1) | o) & 16'hFFFF;
               e_o = (val >> 14) & 1;
            end else
               e_res = ((val << 1) | c) & 16'hFFFF;
            e_s = (e_res >> 15) & 1;
         end
         e_cyc = dbl ? 8 : 6;
         chk("R1", "wr_en", wr_en, 1);
         chk("R1", "wr_sel", wr_sel, op & 3);
         chk("R2", "cycles", cycles, e_cyc);
         chk(rq, "result", result, e_res);
         chk(grp == 8 ? "R5" : rq, "s_out", s_out, e_s);
         chk(grp == 8 ? "R5" : rq, "z_out", z_out, (e_res == 0) ? 1 : 0);
         chk(grp == 8 ? "R5" : rq, "c_out", c_out, e_c);
         chk(grp == 8 ? "R5" : rq, "o_out", o_out, e_o);
      end
   endtask

   initial begin
      int vals[6];
      vals[0] = 16'h0000; vals[1] = 16'h8000; vals[2] = 16'h4001;
      vals[3] = 16'h00FF; vals[4] = 16'hFF00; vals[5] = 16'hC3A5;
      in_valid = 1'b1; opcode = 10'h050; reg_val = 16'hFFFF; c_in = 1'b1;
      repeat (3) @(negedge clk);
      chk("R9", "reset outputs", {wr_en, wr_sel, result, s_out, z_out, c_out, o_out, cycles}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int op = 0; op < 1024; op++) begin
         for (int vi = 0; vi < 6; vi++) begin
            for (int f = 0; f < 4; f++) begin
               run_one(1'b1, op, vals[vi], f[1], f[0]);
            end
         end
      end
      for (int op = 16'h040; op < 16'h058; op++) run_one(1'b0, op, 16'hC3A5, 1'b1, 1'b1);
      run_one(1'b1, 10'h03F, 16'h1234, 1'b1, 1'b0);
      run_one(1'b1, 10'h058, 16'h1234, 1'b1, 1'b0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule